// File: doc/BRIEF.md
# Per-PC Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters. The fetch stage presents a program counter on the lookup port. The same cycle, with no clock edge in the path, the block returns the direction held in the counter that the PC selects.

When a branch resolves later in the pipeline, its PC and real outcome arrive on the update port. The selected counter then moves one step toward the observed direction. A counter needs two wrong outcomes in a row before its prediction flips. Because of this hysteresis, a short loop's closing branch costs one mispredict per pass through the loop, not two.

Table entries carry no tags, so branches whose PCs share the index bits share one counter. The table holds 2^IDX_W entries. The reset input puts every entry into a known starting state.

Top module: `pc_bimodal_pred`

## Requirements
- R1: While reset is asserted, and from then until the first update, every entry holds the weakly-taken state 2'b10, so every lookup predicts taken.
- R2: The prediction is the upper bit of the selected counter. States 2'b00 (strong not-taken) and 2'b01 (weak not-taken) predict not taken. States 2'b10 (weak taken) and 2'b11 (strong taken) predict taken.
- R3: An update with a taken outcome raises the selected counter by one step, provided the counter is below 2'b11.
- R4: An update with a not-taken outcome lowers the selected counter by one step, provided the counter is above 2'b00.
- R5: The counters saturate. A taken update at 2'b11 leaves the state at 2'b11, and a not-taken update at 2'b00 leaves the state at 2'b00.
- R6: The entry index is PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above the index have no effect on which entry is used.
- R7: The lookup result is combinational. When a lookup and an update select the same entry in the same cycle, the lookup shows the old state, and the new state becomes visible only after the clock edge.
- R8: When upd_en is low, no counter changes.
- R9: For a branch that follows the pattern taken, taken, taken, not-taken repeatedly, starting from reset, each pass of four outcomes gives exactly one mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_pc | input | PC_W | Fetch PC to predict |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| upd_en | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and an update can select the same counter in the same cycle. The bench provokes this by driving both ports with one PC while the counter sits at the weakly-taken boundary, where a single not-taken update flips the prediction. It checks two things:
- Before the edge, the prediction still shows taken, the old state.
- Just after the edge, the prediction reads not taken.

The bench also hits one counter through PCs that differ only in the byte offset and in the bits above the index, and confirms that a neighbouring entry does not move.

// File: rtl/pc_bimodal_pred.sv
module pc_bimodal_pred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int OFS   = 2;
  localparam logic [1:0] ST_WEAK_T = 2'b10;
  localparam logic [1:0] ST_MAX    = 2'b11;
  localparam logic [1:0] ST_MIN    = 2'b00;

  logic [DEPTH-1:0][1:0] ctr;
  logic [IDX_W-1:0]      lkp_idx, upd_idx;
  logic [1:0]            cur, nxt;

  assign lkp_idx   = lkp_pc[OFS +: IDX_W];
  assign upd_idx   = upd_pc[OFS +: IDX_W];
  assign lkp_taken = ctr[lkp_idx][1];
  assign cur       = ctr[upd_idx];

  always_comb begin
    nxt = cur;
    if (upd_taken && cur != ST_MAX)       nxt = cur + 2'd1;
    else if (!upd_taken && cur != ST_MIN) nxt = cur - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr <= {DEPTH{ST_WEAK_T}};
    else if (upd_en) ctr[upd_idx] <= nxt;
  end

  // R1
  reset_weak_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> lkp_taken);

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && ctr[upd_idx] != ST_MAX |=>
    ctr[$past(upd_idx)] == $past(ctr[upd_idx]) + 2'd1);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !upd_taken && ctr[upd_idx] != ST_MIN |=>
    ctr[$past(upd_idx)] == $past(ctr[upd_idx]) - 2'd1);

  // R5
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && ctr[upd_idx] == ST_MAX |=> ctr[$past(upd_idx)] == ST_MAX);

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !upd_taken && ctr[upd_idx] == ST_MIN |=> ctr[$past(upd_idx)] == ST_MIN);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ctr));
endmodule

// File: tb/sim_pc_bimodal_pred.sv
module sim_pc_bimodal_pred;
  localparam int PW = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] lkp_pc = '0, upd_pc = '0;
  logic upd_en = 1'b0, upd_taken = 1'b0;
  logic lkp_taken;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pc_bimodal_pred #(.PC_W(PW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // vector: {en, taken, entry[3:0], expected prediction after the edge}
  localparam logic [6:0] VEC [10] = '{
    {1'b1,1'b0,4'd3,1'b0}, {1'b1,1'b0,4'd3,1'b0}, {1'b1,1'b0,4'd3,1'b0},
    {1'b1,1'b1,4'd3,1'b0}, {1'b1,1'b1,4'd3,1'b1}, {1'b1,1'b1,4'd3,1'b1},
    {1'b1,1'b1,4'd3,1'b1}, {1'b1,1'b0,4'd3,1'b1}, {1'b1,1'b0,4'd3,1'b0},
    {1'b0,1'b1,4'd3,1'b0}};
  localparam string VTAG [10] = '{"R4","R4","R5","R3","R3","R3","R5","R4","R2","R8"};

  function automatic logic [PW-1:0] pc_of(input int idx);
    return PW'(idx) << 2;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic upd(input logic [PW-1:0] pc, input logic tk);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_taken = tk;
    @(posedge clk); #1;
    upd_en = 1'b0;
  endtask

  task automatic look(input logic [PW-1:0] pc, input string tag, input logic exp);
    @(negedge clk);
    lkp_pc = pc; #1;
    check(tag, lkp_taken, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", lkp_taken, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    look(pc_of(0), "R1", 1'b1);
    look(pc_of(63), "R1", 1'b1);
    look(pc_of(17) | 32'h3, "R1", 1'b1);

    // table-driven walk on one entry
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      upd_en = VEC[i][6]; upd_taken = VEC[i][5];
      upd_pc = pc_of(int'(VEC[i][4:1])); lkp_pc = upd_pc;
      @(posedge clk); #1;
      upd_en = 1'b0;
      check(VTAG[i], lkp_taken, VEC[i][0]);
    end

    // R6: byte offset and high bits ignored
    upd(pc_of(5) | 32'h3 | (32'h1 << (IW + 2)), 1'b0);
    upd(pc_of(5) | 32'h1 | (32'h5 << (IW + 3)), 1'b0);
    look(pc_of(5), "R6", 1'b0);
    look(pc_of(5) | 32'h2 | 32'h8000_0000, "R6", 1'b0);
    look(pc_of(6), "R6", 1'b1);
    look(pc_of(4), "R6", 1'b1);

    // R7: same-entry lookup and update in one cycle
    @(negedge clk);
    lkp_pc = pc_of(7); upd_pc = pc_of(7); upd_en = 1'b1; upd_taken = 1'b0;
    #1 check("R7", lkp_taken, 1'b1);
    @(posedge clk); #1;
    upd_en = 1'b0;
    check("R7", lkp_taken, 1'b0);

    // R9: loop branch T,T,T,NT
    for (int p = 0; p < 4; p++) begin
      int miss;
      miss = 0;
      for (int k = 0; k < 4; k++) begin
        logic act;
        act = (k != 3);
        @(negedge clk);
        lkp_pc = pc_of(9); #1;
        if (lkp_taken != act) miss++;
        upd(pc_of(9), act);
      end
      n_chk++;
      if (miss != 1) begin
        n_bad++;
        $display("FAIL R9: got %0d mispredicts expected 1", miss);
      end
    end

    // R1: reset mid-run restores weak taken
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    look(pc_of(5), "R1", 1'b1);
    look(pc_of(3), "R1", 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule